// File: doc/BRIEF.md
# Prefetch Burst Serializer for a Synchronous DRAM Data Path

This block models the data path between the wide core word of a synchronous DRAM and its narrow external data pins. On a read, one core word of prefetch × N bits is loaded in a single cycle. It is then sent out as a burst of N-bit beats, lowest slice first. On a write, the block gathers beats from the pins back into a core word. A two-bit generation input selects one of four memory types. The type sets the prefetch depth (1, 2, 4 or 8 beats) and whether beats move on one clock edge or on both.

All logic runs on one clock, `clk`, which counts half-periods of the interface clock (slots). In the double-rate types each slot carries one beat. In the single-rate type a beat occupies both slots of an interface period, so it changes only at rising edges. As a result, the interface clock equals the core clock for prefetch 1 and 2, is twice the core clock for prefetch 4 and is four times it for prefetch 8. A strobe output marks each beat of a read burst. A busy output tells the core when it may present the next word.

Top module: `pfser_top`

## Requirements
- R1: After reset, `busy`, `dq_oe`, `dq_strobe`, `rd_first` and `wr_word_valid` are 0 and `dq_out` is 0.
- R2: `gen` encodes the memory type: 0 is single-rate with prefetch 1, 1 is double-rate with prefetch 2, 2 is double-rate with prefetch 4 and 3 is double-rate with prefetch 8. A read burst therefore has 1, 2, 4 or 8 beats.
- R3: Beat k of a read burst drives `rd_word[k*DQ_W +: DQ_W]` on `dq_out`, so the least significant slice goes first.
- R4: In the double-rate types each beat lasts one `clk` cycle. In the single-rate type each beat lasts two `clk` cycles. `dq_oe` is 1 for exactly the beats of the burst.
- R5: `rd_first` is 1 for the whole of the first beat of a burst and 0 otherwise.
- R6: `dq_strobe` is 0 when no burst is running. During a burst it is 1 on even-numbered beats and 0 on odd ones, so it changes at every beat boundary.
- R7: `busy` is 1 from the cycle after a load is accepted until the final slot of the burst. A `rd_load` seen while `busy` is 1 is dropped: the running burst is unchanged and no burst follows it.
- R8: A load presented in the final slot of a burst is accepted, and its first beat follows the previous last beat with no idle slot.
- R9: A write completes after `gen`'s prefetch count of `wr_valid` beats. In the next cycle `wr_word_valid` pulses for one cycle, and `wr_word` then holds the beats with the first beat in the lowest slice and all bits above prefetch × DQ_W at 0.
- R10: Cycles with `wr_valid` at 0 are skipped and do not split a write word.
- R11: `gen` is sampled when a read burst is loaded or when the first beat of a write arrives. Changes to `gen` during a burst do not alter its length or its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, two cycles per interface clock period |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen | input | 2 | Memory type select (R2 encoding) |
| rd_load | input | 1 | Request to load a core word for a read burst |
| rd_word | input | DQ_W*8 | Core word to send |
| busy | output | 1 | A read burst still has slots beyond this one |
| dq_out | output | DQ_W | Read beat on the data pins |
| dq_oe | output | 1 | Data pins are being driven |
| dq_strobe | output | 1 | Beat strobe |
| rd_first | output | 1 | The current beat is the first of its burst |
| wr_valid | input | 1 | A write beat is present on `dq_in` |
| dq_in | input | DQ_W | Write beat |
| wr_word | output | DQ_W*8 | Gathered core word |
| wr_word_valid | output | 1 | One-cycle pulse when `wr_word` is complete |

## Verification
On every cycle, the checker confirms that a burst begins only after a load and that it opens with the first-beat flag and a high strobe. It also confirms that busy never ends a burst early, that a burst ends only after a non-busy slot, and that a completed write word follows an accepted beat. The per-beat data order, the beat length for each memory type, the strobe pattern, the dropping of loads during a burst, seamless chaining and the masking of unused write bits depend on the word and type applied. These are shown only by the bench's scenarios, which compare each slot against values computed from the requirements.

// File: rtl/pfser_pkg.sv
package pfser_pkg;

   typedef enum logic [1:0] {
      GEN_SDR  = 2'd0,
      GEN_DDR1 = 2'd1,
      GEN_DDR2 = 2'd2,
      GEN_DDR3 = 2'd3
   } gen_e;

   localparam int MAX_PREFETCH = 8;
   localparam int CNT_W        = 4;

   function automatic logic [CNT_W-1:0] beats_of(input gen_e g);
      return CNT_W'(1) << g;
   endfunction

endpackage

// File: rtl/pfser_mode_dec.sv
module pfser_mode_dec
   import pfser_pkg::*;
(
   input  logic [1:0]       gen,
   output logic [CNT_W-1:0] beats,
   output logic             single_rate
);

   gen_e g;

   always_comb begin
      g           = gen_e'(gen);
      beats       = beats_of(g);
      single_rate = (g == GEN_SDR);
   end

endmodule

// File: rtl/pfser_rd_shift.sv
module pfser_rd_shift
   import pfser_pkg::*;
#(
   parameter int DQ_W   = 8,
   parameter int WORD_W = DQ_W * MAX_PREFETCH
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_req,
   input  logic [WORD_W-1:0] load_word,
   input  logic [CNT_W-1:0]  beats_in,
   input  logic              sdr_in,
   output logic [DQ_W-1:0]   dq,
   output logic              oe,
   output logic              strobe,
   output logic              first,
   output logic              busy_o
);

   logic [WORD_W-1:0] sreg;
   logic [CNT_W-1:0]  left;
   logic [2:0]        idx;
   logic              half;
   logic              sdr_q;
   logic              active;
   logic              beat_end;
   logic              last_slot;
   logic              take;

   always_comb begin
      beat_end  = !sdr_q || half;
      last_slot = active && (left == CNT_W'(1)) && beat_end;
      busy_o    = active && !last_slot;
      take      = load_req && !busy_o;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg   <= '0;
         left   <= '0;
         idx    <= '0;
         half   <= 1'b0;
         sdr_q  <= 1'b0;
         active <= 1'b0;
      end else if (take) begin
         sreg   <= load_word;
         left   <= beats_in;
         idx    <= '0;
         half   <= 1'b0;
         sdr_q  <= sdr_in;
         active <= 1'b1;
      end else if (active) begin
         if (beat_end) begin
            half <= 1'b0;
            if (left == CNT_W'(1)) begin
               active <= 1'b0;
            end else begin
               sreg <= sreg >> DQ_W;
               left <= left - CNT_W'(1);
               idx  <= idx + 3'd1;
            end
         end else begin
            half <= 1'b1;
         end
      end
   end

   always_comb begin
      dq     = active ? sreg[DQ_W-1:0] : '0;
      oe     = active;
      strobe = active && !idx[0];
      first  = active && (idx == 3'd0);
   end

endmodule

// File: rtl/pfser_wr_pack.sv
module pfser_wr_pack
   import pfser_pkg::*;
#(
   parameter int DQ_W   = 8,
   parameter int WORD_W = DQ_W * MAX_PREFETCH
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              beat_valid,
   input  logic [DQ_W-1:0]   beat,
   input  logic [CNT_W-1:0]  beats_in,
   output logic [WORD_W-1:0] word,
   output logic              word_valid
);

   logic [WORD_W-1:0] acc;
   logic [WORD_W-1:0] nxt;
   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  tgt;
   logic [CNT_W-1:0]  cur_tgt;
   logic [CNT_W-1:0]  cnt_inc;

   always_comb begin
      cur_tgt = (cnt == '0) ? beats_in : tgt;
      cnt_inc = cnt + CNT_W'(1);
      nxt     = (cnt == '0) ? '0 : acc;
      nxt[int'(cnt[2:0])*DQ_W +: DQ_W] = beat;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc        <= '0;
         cnt        <= '0;
         tgt        <= '0;
         word       <= '0;
         word_valid <= 1'b0;
      end else begin
         word_valid <= 1'b0;
         if (beat_valid) begin
            acc <= nxt;
            tgt <= cur_tgt;
            if (cnt_inc == cur_tgt) begin
               cnt        <= '0;
               word       <= nxt;
               word_valid <= 1'b1;
            end else begin
               cnt <= cnt_inc;
            end
         end
      end
   end

endmodule

// File: rtl/pfser_top.sv
module pfser_top
   import pfser_pkg::*;
#(
   parameter int DQ_W = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [1:0]                   gen,
   input  logic                         rd_load,
   input  logic [DQ_W*MAX_PREFETCH-1:0] rd_word,
   output logic                         busy,
   output logic [DQ_W-1:0]              dq_out,
   output logic                         dq_oe,
   output logic                         dq_strobe,
   output logic                         rd_first,
   input  logic                         wr_valid,
   input  logic [DQ_W-1:0]              dq_in,
   output logic [DQ_W*MAX_PREFETCH-1:0] wr_word,
   output logic                         wr_word_valid
);

   localparam int WORD_W = DQ_W * MAX_PREFETCH;

   generate
      if (!(DQ_W == 4 || DQ_W == 8 || DQ_W == 16)) begin : g_bad_width
         $error("pfser_top: DQ_W must be 4, 8 or 16");
      end
   endgenerate

   logic [CNT_W-1:0] beats;
   logic             single_rate;

   pfser_mode_dec u_dec (
      .gen         (gen),
      .beats       (beats),
      .single_rate (single_rate)
   );

   pfser_rd_shift #(.DQ_W(DQ_W), .WORD_W(WORD_W)) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_req  (rd_load),
      .load_word (rd_word),
      .beats_in  (beats),
      .sdr_in    (single_rate),
      .dq        (dq_out),
      .oe        (dq_oe),
      .strobe    (dq_strobe),
      .first     (rd_first),
      .busy_o    (busy)
   );

   pfser_wr_pack #(.DQ_W(DQ_W), .WORD_W(WORD_W)) u_wr (
      .clk        (clk),
      .rst_n      (rst_n),
      .beat_valid (wr_valid),
      .beat       (dq_in),
      .beats_in   (beats),
      .word       (wr_word),
      .word_valid (wr_word_valid)
   );

endmodule

// File: rtl/pfser_chk.sv
module pfser_chk (
   input logic clk,
   input logic rst_n,
   input logic rd_load,
   input logic busy,
   input logic dq_oe,
   input logic dq_strobe,
   input logic rd_first,
   input logic wr_valid,
   input logic wr_word_valid
);

   assert_burst_needs_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dq_oe) |-> $past(rd_load));

   assert_open_marks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dq_oe) |-> (rd_first && dq_strobe));

   assert_busy_has_burst_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> dq_oe);

   assert_busy_continues_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> dq_oe);

   assert_end_after_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dq_oe) |-> !$past(busy));

   assert_word_after_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_word_valid |-> $past(wr_valid));

endmodule

bind pfser_top pfser_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .rd_load       (rd_load),
   .busy          (busy),
   .dq_oe         (dq_oe),
   .dq_strobe     (dq_strobe),
   .rd_first      (rd_first),
   .wr_valid      (wr_valid),
   .wr_word_valid (wr_word_valid)
);

// File: tb/pfser_top_tb_top.sv
`timescale 1ns/1ps
module pfser_top_tb_top;

   localparam int DQ_W   = 8;
   localparam int WORD_W = 64;
   localparam int NVEC   = 4;

   localparam logic [1:0]  V_GEN  [NVEC] = '{2'd0, 2'd1, 2'd2, 2'd3};
   localparam logic [63:0] V_WORD [NVEC] = '{64'h0123_4567_89AB_CDEF,
                                            64'hFEDC_BA98_7654_3210,
                                            64'hA5A5_5A5A_C3C3_3C3C,
                                            64'h1122_3344_5566_7788};

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [1:0]        gen = 2'd0;
   logic              rd_load = 1'b0;
   logic [WORD_W-1:0] rd_word = '0;
   logic              busy;
   logic [DQ_W-1:0]   dq_out;
   logic              dq_oe;
   logic              dq_strobe;
   logic              rd_first;
   logic              wr_valid = 1'b0;
   logic [DQ_W-1:0]   dq_in = '0;
   logic [WORD_W-1:0] wr_word;
   logic              wr_word_valid;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   pfser_top #(.DQ_W(DQ_W)) dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .gen           (gen),
      .rd_load       (rd_load),
      .rd_word       (rd_word),
      .busy          (busy),
      .dq_out        (dq_out),
      .dq_oe         (dq_oe),
      .dq_strobe     (dq_strobe),
      .rd_first      (rd_first),
      .wr_valid      (wr_valid),
      .dq_in         (dq_in),
      .wr_word       (wr_word),
      .wr_word_valid (wr_word_valid)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] mask_word(input logic [1:0] g, input logic [63:0] w);
      int nb = 1 << g;
      if (nb == 8) return w;
      return w & ((64'd1 << (nb * DQ_W)) - 64'd1);
   endfunction

   // Issue a load at the next edge; the caller is at a falling edge.
   task automatic start_rd(input logic [1:0] g, input logic [63:0] w);
      chk(busy == 1'b0, "R7 free before load", 64'(busy), 64'd0);
      gen     = g;
      rd_load = 1'b1;
      rd_word = w;
      @(negedge clk);
      rd_load = 1'b0;
   endtask

   // Walk one running burst slot by slot.
   task automatic run_rd(input logic [1:0] g, input logic [63:0] w,
                         input bit chg, input bit poke, input bit chain, input logic [63:0] w2);
      int nb = 1 << g;
      int sp = (g == 2'd0) ? 2 : 1;
      for (int k = 0; k < nb; k++) begin
         for (int s = 0; s < sp; s++) begin
            bit last = (k == nb - 1) && (s == sp - 1);
            logic [7:0] sl = w[k*DQ_W +: DQ_W];
            chk(dq_out == sl, "R3 beat data", 64'(dq_out), 64'(sl));
            chk(dq_oe == 1'b1, "R4 beat length", 64'(dq_oe), 64'd1);
            chk(dq_strobe == !k[0], "R6 strobe per beat", 64'(dq_strobe), 64'(!k[0]));
            chk(rd_first == (k == 0), "R5 first-beat flag", 64'(rd_first), 64'(k == 0));
            chk(busy == !last, "R7 busy until final slot", 64'(busy), 64'(!last));
            if (chg && k == 0 && s == 0) gen = ~g;
            if (poke && k == 0 && s == 0) begin
               rd_load = 1'b1;
               rd_word = ~w;
            end
            if (chain && last) begin
               rd_load = 1'b1;
               rd_word = w2;
            end
            @(negedge clk);
            rd_load = 1'b0;
         end
      end
      gen = g;
      if (!chain) begin
         chk(dq_oe == 1'b0, "R4 burst over after R2 count", 64'(dq_oe), 64'd0);
         chk(dq_strobe == 1'b0, "R6 strobe low when idle", 64'(dq_strobe), 64'd0);
         chk(dq_out == '0, "R7 no queued burst", 64'(dq_out), 64'd0);
      end
   endtask

   task automatic run_wr(input logic [1:0] g, input logic [63:0] w, input bit gaps, input bit chg);
      int nb = 1 << g;
      gen = g;
      for (int k = 0; k < nb; k++) begin
         if (chg && k == 1) gen = ~g;
         wr_valid = 1'b1;
         dq_in    = w[k*DQ_W +: DQ_W];
         @(negedge clk);
         if (k < nb - 1) begin
            chk(wr_word_valid == 1'b0, "R9 no word before last beat", 64'(wr_word_valid), 64'd0);
            if (gaps) begin
               wr_valid = 1'b0;
               dq_in    = 8'hEE;
               @(negedge clk);
               @(negedge clk);
               chk(wr_word_valid == 1'b0, "R10 gap holds word", 64'(wr_word_valid), 64'd0);
            end
         end
      end
      wr_valid = 1'b0;
      chk(wr_word_valid == 1'b1, "R9 word valid pulse", 64'(wr_word_valid), 64'd1);
      chk(wr_word == mask_word(g, w), "R9 gathered word", wr_word, mask_word(g, w));
      gen = g;
      @(negedge clk);
      chk(wr_word_valid == 1'b0, "R9 pulse one cycle", 64'(wr_word_valid), 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(busy == 1'b0, "R1 reset busy", 64'(busy), 64'd0);
      chk(dq_oe == 1'b0, "R1 reset oe", 64'(dq_oe), 64'd0);
      chk(dq_strobe == 1'b0, "R1 reset strobe", 64'(dq_strobe), 64'd0);
      chk(rd_first == 1'b0, "R1 reset first", 64'(rd_first), 64'd0);
      chk(dq_out == '0, "R1 reset data", 64'(dq_out), 64'd0);
      chk(wr_word_valid == 1'b0, "R1 reset write valid", 64'(wr_word_valid), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // Table walk: each type, read then write (R2, R3, R4, R9).
      for (int v = 0; v < NVEC; v++) begin
         start_rd(V_GEN[v], V_WORD[v]);
         run_rd(V_GEN[v], V_WORD[v], 1'b0, 1'b0, 1'b0, '0);
         run_wr(V_GEN[v], V_WORD[v], 1'b0, 1'b0);
      end

      // R7: load during a burst is dropped.
      start_rd(2'd2, 64'h0000_0000_DEAD_BEEF);
      run_rd(2'd2, 64'h0000_0000_DEAD_BEEF, 1'b0, 1'b1, 1'b0, '0);

      // R8: back-to-back bursts, single-rate and widest type.
      start_rd(2'd0, 64'h0000_0000_0000_0011);
      run_rd(2'd0, 64'h0000_0000_0000_0011, 1'b0, 1'b0, 1'b1, 64'h0000_0000_0000_0022);
      run_rd(2'd0, 64'h0000_0000_0000_0022, 1'b0, 1'b0, 1'b0, '0);
      start_rd(2'd3, 64'h8877_6655_4433_2211);
      run_rd(2'd3, 64'h8877_6655_4433_2211, 1'b0, 1'b0, 1'b1, 64'h0F1E_2D3C_4B5A_6978);
      run_rd(2'd3, 64'h0F1E_2D3C_4B5A_6978, 1'b0, 1'b0, 1'b0, '0);

      // R11: type change during read and write bursts.
      start_rd(2'd3, 64'hCAFE_F00D_1234_5678);
      run_rd(2'd3, 64'hCAFE_F00D_1234_5678, 1'b1, 1'b0, 1'b0, '0);
      start_rd(2'd0, 64'h0000_0000_0000_00A7);
      run_rd(2'd0, 64'h0000_0000_0000_00A7, 1'b1, 1'b0, 1'b0, '0);
      run_wr(2'd2, 64'hFFFF_FFFF_9ABC_DEF0, 1'b0, 1'b1);

      // R10: gaps between write beats; R9 upper bits cleared.
      run_wr(2'd3, 64'h0102_0304_0506_0708, 1'b1, 1'b0);
      run_wr(2'd1, 64'hFFFF_FFFF_FFFF_5AA5, 1'b1, 1'b0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

endmodule